// File: doc/BRIEF.md
# Pixel Gain, LUT and Output Formatter

This block sits in a camera video path and conditions a stream of 10-bit pixels. Each accepted pixel is first scaled by an unsigned fixed-point gain with four integer and four fractional bits. Results above 1023 saturate at 1023. The scaled value can then be remapped through a 1024-entry table of 10-bit values, or pass through unchanged. A final stage turns the value into a 16-bit output word. A 4-bit format code picks the packing. One code replaces the video with a per-line ramp pattern.

Software reaches the block through a small register port with four word addresses. One address holds the format code and the table enable. One holds the gain. One holds the table index. The last is the table data window. Each access to the data window, read or write, moves the index on by one, so the whole table can be loaded or dumped in one burst after a single index write. The pixel path has three register stages. Packing is done in the last of them.

Top module: `pix_tone_fmt`

## Requirements
- R1: After reset, outValid and regRdData are 0. The control register (address 0) reads 0, the gain register (address 1) reads 0x10 and the table index (address 2) reads 0.
- R2: The tone value is min(1023, floor(pixIn × gain / 16)), with the gain an 8-bit unsigned value with 4 fractional bits.
- R3: When bit 4 of the control register is 1, the tone value is replaced by table entry [tone]. When that bit is 0, the table is skipped.
- R4: Writing address 2 loads the 10-bit table index. Every write or read of address 3 increments the index by one, wrapping from 1023 to 0. No other access changes it.
- R5: A write to address 3 stores bits [9:0] at the current index. A read of address 3 returns the entry at the current index in regRdData[9:0], one cycle after regRdEn. All register reads return their data in that same cycle.
- R6: Format code 0000 (control bits [3:0]) outputs the upper 8 bits of the tone value in outData[7:0], with outData[15:8] zero. Every code other than 0001, 0010, 0100 and 1000 behaves the same way.
- R7: Format code 0001 outputs the tone value in outData[15:6], with outData[5:0] zero.
- R8: Format code 0010 outputs the tone value in outData[9:0], with outData[15:10] zero.
- R9: Format code 1000 packs tone values densely, low bits first. The first pixel fills bits [9:0] of the first word, and each later pixel continues at the next free bit, spilling into the next word. outValid rises only when a 16-bit word is full, so 8 pixels produce 5 words.
- R10: Format code 0100 outputs a ramp in outData[9:0], with gain and table ignored. The ramp value is 0 on a valid pixel that has lineStart high. Otherwise it is the previous valid pixel's ramp value plus 1, modulo 1024.
- R11: Except for code 1000, outValid equals pixValid delayed by exactly three clock cycles, and outData carries the result for that pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| pixIn | input | 10 | Pixel value |
| pixValid | input | 1 | pixIn holds a pixel this cycle |
| lineStart | input | 1 | Pixel is the first of a line (restarts the ramp) |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 2 | Register address: 0 control, 1 gain, 2 table index, 3 table data |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data, valid the cycle after regRdEn |
| outData | output | 16 | Formatted output word |
| outValid | output | 1 | outData holds a new word |

## Verification
A table index that slips by one shows up when the table is read back: the read returns a neighbouring entry, and mapped video carries the wrong values from the first pixel onward. A wrong gain scale or a missing clip shows on the first pixel whose true product passes 1023, three cycles after that pixel enters. A packer that loses or duplicates its leftover bits corrupts the second word of a burst, and every word after it stays shifted. A ramp counter that ignores lineStart is caught on the first line boundary.

// File: rtl/pix_tone_pkg.sv
package pix_tone_pkg;
  localparam int PIX_W     = 10;
  localparam int GAIN_W    = 8;
  localparam int GAIN_FRAC = 4;
  localparam int FMT_W     = 4;
  localparam int OUT_W     = 16;
  localparam int REG_W     = 16;
  localparam int RADDR_W   = 2;
  localparam int BYTE_W    = 8;
  localparam int LUT_DEPTH = 1 << PIX_W;

  localparam logic [FMT_W-1:0] FMT_BYTE  = 4'b0000;
  localparam logic [FMT_W-1:0] FMT_LEFT  = 4'b0001;
  localparam logic [FMT_W-1:0] FMT_RIGHT = 4'b0010;
  localparam logic [FMT_W-1:0] FMT_RAMP  = 4'b0100;
  localparam logic [FMT_W-1:0] FMT_PACK  = 4'b1000;

  localparam logic [RADDR_W-1:0] RA_CTRL  = 2'd0;
  localparam logic [RADDR_W-1:0] RA_GAIN  = 2'd1;
  localparam logic [RADDR_W-1:0] RA_LIDX  = 2'd2;
  localparam logic [RADDR_W-1:0] RA_LDATA = 2'd3;

  localparam logic [GAIN_W-1:0] GAIN_UNITY = GAIN_W'(1 << GAIN_FRAC);

  // Strobes and settings handed from control to datapath
  typedef struct packed {
    logic [FMT_W-1:0]  fmt;
    logic              lutOn;
    logic [GAIN_W-1:0] gain;
    logic              lutWr;
    logic [PIX_W-1:0]  lutIdx;
    logic [PIX_W-1:0]  lutWrData;
  } tone_cmd_t;
endpackage

// File: rtl/pix_tone_ctrl.sv
module pix_tone_ctrl
  import pix_tone_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [RADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]   regWrData,
  input  logic [PIX_W-1:0]   lutRdData,
  output logic [REG_W-1:0]   regRdData,
  output tone_cmd_t          cmd
);
  logic [FMT_W-1:0]  fmtReg;
  logic              lutOnReg;
  logic [GAIN_W-1:0] gainReg;
  logic [PIX_W-1:0]  idxReg;
  logic              dataHit;
  logic [REG_W-1:0]  rdMux;
  logic              unusedWrBits;

  assign unusedWrBits = ^regWrData[REG_W-1:PIX_W];
  assign dataHit = (regAddr == RA_LDATA) && (regWrEn || regRdEn);

  always_comb begin
    case (regAddr)
      RA_CTRL: rdMux = REG_W'({lutOnReg, fmtReg});
      RA_GAIN: rdMux = REG_W'(gainReg);
      RA_LIDX: rdMux = REG_W'(idxReg);
      default: rdMux = REG_W'(lutRdData);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fmtReg    <= FMT_BYTE;
      lutOnReg  <= 1'b0;
      gainReg   <= GAIN_UNITY;
      idxReg    <= '0;
      regRdData <= '0;
    end else begin
      if (regWrEn) begin
        case (regAddr)
          RA_CTRL: begin
            fmtReg   <= regWrData[FMT_W-1:0];
            lutOnReg <= regWrData[FMT_W];
          end
          RA_GAIN: gainReg <= regWrData[GAIN_W-1:0];
          RA_LIDX: idxReg  <= regWrData[PIX_W-1:0];
          default: ;
        endcase
      end
      if (dataHit) idxReg <= idxReg + 1'b1;
      if (regRdEn) regRdData <= rdMux;
    end
  end

  assign cmd.fmt       = fmtReg;
  assign cmd.lutOn     = lutOnReg;
  assign cmd.gain      = gainReg;
  assign cmd.lutWr     = regWrEn && (regAddr == RA_LDATA);
  assign cmd.lutIdx    = idxReg;
  assign cmd.lutWrData = regWrData[PIX_W-1:0];
endmodule

// File: rtl/pix_tone_dp.sv
module pix_tone_dp
  import pix_tone_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  tone_cmd_t        cmd,
  input  logic [PIX_W-1:0] pixIn,
  input  logic             pixValid,
  input  logic             lineStart,
  output logic [PIX_W-1:0] lutRdData,
  output logic [OUT_W-1:0] outData,
  output logic             outValid
);
  localparam int PROD_W = PIX_W + GAIN_W;
  localparam int SCL_W  = PROD_W - GAIN_FRAC;
  localparam int ACC_W  = OUT_W + PIX_W;
  localparam int CNT_W  = $clog2(OUT_W);
  localparam logic [PIX_W-1:0] PIX_MAX = '1;

  logic [PIX_W-1:0] lutMem [LUT_DEPTH];

  always_ff @(posedge clk) begin
    if (cmd.lutWr) lutMem[cmd.lutIdx] <= cmd.lutWrData;
  end
  assign lutRdData = lutMem[cmd.lutIdx];

  // Stage 1: gain and saturation
  logic [PROD_W-1:0] prod;
  logic [SCL_W-1:0]  scaled;
  logic [PIX_W-1:0]  clipped;
  assign prod = PROD_W'(pixIn) * PROD_W'(cmd.gain);
  generate
    if (GAIN_FRAC > 0) begin : g_frac
      assign scaled = prod[PROD_W-1:GAIN_FRAC];
    end else begin : g_int
      assign scaled = prod;
    end
  endgenerate
  assign clipped = (scaled > SCL_W'(PIX_MAX)) ? PIX_MAX : scaled[PIX_W-1:0];

  logic [PIX_W-1:0] rampCnt, rampCur;
  assign rampCur = lineStart ? '0 : rampCnt;

  logic             s1Val, s2Val;
  logic [PIX_W-1:0] s1Tone, s1Ramp, s2Tone, s2Ramp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Val   <= 1'b0;
      s1Tone  <= '0;
      s1Ramp  <= '0;
      rampCnt <= '0;
    end else begin
      s1Val <= pixValid;
      if (pixValid) begin
        s1Tone  <= clipped;
        s1Ramp  <= rampCur;
        rampCnt <= rampCur + 1'b1;
      end
    end
  end

  // Stage 2: optional table remap
  always_ff @(posedge clk) begin
    if (!rstN) begin
      s2Val  <= 1'b0;
      s2Tone <= '0;
      s2Ramp <= '0;
    end else begin
      s2Val  <= s1Val;
      s2Tone <= cmd.lutOn ? lutMem[s1Tone] : s1Tone;
      s2Ramp <= s1Ramp;
    end
  end

  // Stage 3: formatting and dense packing
  logic [OUT_W-1:0] fmtWord;
  always_comb begin
    case (cmd.fmt)
      FMT_LEFT:  fmtWord = {s2Tone, {(OUT_W-PIX_W){1'b0}}};
      FMT_RIGHT: fmtWord = OUT_W'(s2Tone);
      FMT_RAMP:  fmtWord = OUT_W'(s2Ramp);
      default:   fmtWord = OUT_W'(s2Tone[PIX_W-1 -: BYTE_W]);
    endcase
  end

  logic [OUT_W-1:0] packAcc;
  logic [CNT_W-1:0] packCnt;
  logic [ACC_W-1:0] packMerged;
  logic [CNT_W:0]   packFill;
  logic             packFull;

  assign packMerged = ACC_W'(packAcc) | (ACC_W'(s2Tone) << packCnt);
  assign packFill   = {1'b0, packCnt} + (CNT_W+1)'(PIX_W);
  assign packFull   = packFill >= (CNT_W+1)'(OUT_W);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      packAcc  <= '0;
      packCnt  <= '0;
    end else if (cmd.fmt == FMT_PACK) begin
      outValid <= s2Val && packFull;
      if (s2Val) begin
        if (packFull) begin
          outData <= packMerged[OUT_W-1:0];
          packAcc <= OUT_W'(packMerged >> OUT_W);
          packCnt <= CNT_W'(packFill - (CNT_W+1)'(OUT_W));
        end else begin
          packAcc <= packMerged[OUT_W-1:0];
          packCnt <= packFill[CNT_W-1:0];
        end
      end
    end else begin
      outValid <= s2Val;
      if (s2Val) outData <= fmtWord;
      packAcc <= '0;
      packCnt <= '0;
    end
  end
endmodule

// File: rtl/pix_tone_fmt.sv
module pix_tone_fmt
  import pix_tone_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [PIX_W-1:0]   pixIn,
  input  logic               pixValid,
  input  logic               lineStart,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [RADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  output logic [OUT_W-1:0]   outData,
  output logic               outValid
);
  tone_cmd_t        cmd;
  logic [PIX_W-1:0] lutRdData;

  pix_tone_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .lutRdData(lutRdData),
    .regRdData(regRdData), .cmd(cmd)
  );

  pix_tone_dp u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .pixIn(pixIn), .pixValid(pixValid),
    .lineStart(lineStart), .lutRdData(lutRdData), .outData(outData),
    .outValid(outValid)
  );
endmodule

// File: rtl/pix_tone_fmt_chk.sv
module pix_tone_fmt_chk
  import pix_tone_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               pixValid,
  input logic               outValid,
  input logic [OUT_W-1:0]   outData,
  input logic [REG_W-1:0]   regRdData,
  input logic               regWrEn,
  input logic               regRdEn,
  input logic [RADDR_W-1:0] regAddr,
  input logic [FMT_W-1:0]   fmtNow,
  input logic [PIX_W-1:0]   lutIdx
);
  logic [2:0]       sinceRst;
  logic [2:0]       fmtAge;
  logic [FMT_W-1:0] fmtPrev;
  logic             settled;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceRst <= '0;
      fmtAge   <= '0;
      fmtPrev  <= fmtNow;
    end else begin
      if (sinceRst != 3'd7) sinceRst <= sinceRst + 1'b1;
      fmtPrev <= fmtNow;
      if (fmtNow != fmtPrev) fmtAge <= '0;
      else if (fmtAge != 3'd7) fmtAge <= fmtAge + 1'b1;
    end
  end
  assign settled = (sinceRst >= 3'd3) && (fmtAge >= 3'd3);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!outValid && regRdData == '0));

  a_r11_valid_delay: assert property (@(posedge clk) disable iff (!rstN)
    (settled && fmtNow != FMT_PACK) |-> (outValid == $past(pixValid, 3)));

  a_r9_pack_needs_pixel: assert property (@(posedge clk) disable iff (!rstN)
    (settled && fmtNow == FMT_PACK && outValid) |-> $past(pixValid, 3));

  a_r4_index_step: assert property (@(posedge clk) disable iff (!rstN)
    ((regWrEn || regRdEn) && regAddr == RA_LDATA) |=> (lutIdx == 10'($past(lutIdx) + 10'd1)));

  a_r4_index_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!regWrEn && !(regRdEn && regAddr == RA_LDATA)) |=> $stable(lutIdx));

  a_r6_byte_high_zero: assert property (@(posedge clk) disable iff (!rstN)
    (settled && outValid && fmtNow != FMT_LEFT && fmtNow != FMT_RIGHT &&
     fmtNow != FMT_RAMP && fmtNow != FMT_PACK) |-> (outData[OUT_W-1:BYTE_W] == '0));

  a_r7_left_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    (settled && outValid && fmtNow == FMT_LEFT) |-> (outData[OUT_W-PIX_W-1:0] == '0));

  a_r8_right_high_zero: assert property (@(posedge clk) disable iff (!rstN)
    (settled && outValid && fmtNow == FMT_RIGHT) |-> (outData[OUT_W-1:PIX_W] == '0));
endmodule

bind pix_tone_fmt pix_tone_fmt_chk u_chk (
  .clk(clk), .rstN(rstN), .pixValid(pixValid), .outValid(outValid),
  .outData(outData), .regRdData(regRdData), .regWrEn(regWrEn),
  .regRdEn(regRdEn), .regAddr(regAddr), .fmtNow(cmd.fmt), .lutIdx(cmd.lutIdx)
);

// File: tb/sim_pix_tone_fmt.sv
module sim_pix_tone_fmt;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  pixIn = '0;
  logic        pixValid = 1'b0;
  logic        lineStart = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [15:0] outData;
  logic        outValid;

  int nCmp = 0;
  int nBad = 0;
  int lutModel [1024];

  always #4 clk = ~clk;

  pix_tone_fmt u0 (
    .clk(clk), .rstN(rstN), .pixIn(pixIn), .pixValid(pixValid),
    .lineStart(lineStart), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .outData(outData), .outValid(outValid)
  );

  task automatic checkVal(input bit ok, input string tag,
                          input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic runStream(input logic [3:0] f, input int g, input bit lon,
                           input int lineLen, input string tag);
    logic        expV [8];
    logic [15:0] expD [8];
    logic [31:0] acc;
    int cnt, rc, k, v, rv;
    bit pv, ls;
    logic [15:0] w;
    regWrite(2'd1, 16'(g));
    regWrite(2'd0, {11'b0, lon, f});
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) begin expV[i] = 1'b0; expD[i] = '0; end
    acc = '0; cnt = 0; rc = 0; k = 0;
    for (int c = 0; c < 1204; c++) begin
      @(negedge clk);
      checkVal((outValid === expV[c%8]) && (!expV[c%8] || outData === expD[c%8]),
               tag, {15'b0, outValid, outData}, {15'b0, expV[c%8], expD[c%8]});
      pv = (c < 1200) && ((c % 7) != 6);
      ls = pv && (lineLen > 0) && ((k % lineLen) == 0);
      pixValid = pv; lineStart = ls;
      pixIn = 10'((k * 389 + 11) % 1024);
      expV[(c+3)%8] = 1'b0;
      if (pv) begin
        v = (int'(pixIn) * g) >> 4;
        if (v > 1023) v = 1023;
        if (lon) v = lutModel[v];
        rv = ls ? 0 : rc;
        rc = (rv + 1) % 1024;
        case (f)
          4'b0001: w = {10'(v), 6'b0};
          4'b0010: w = 16'(v);
          4'b0100: w = 16'(rv);
          default: w = {8'b0, 8'(v >> 2)};
        endcase
        if (f == 4'b1000) begin
          acc = acc | (32'(v) << cnt);
          cnt = cnt + 10;
          if (cnt >= 16) begin
            expV[(c+3)%8] = 1'b1; expD[(c+3)%8] = acc[15:0];
            acc = acc >> 16; cnt = cnt - 16;
          end
        end else begin
          expV[(c+3)%8] = 1'b1; expD[(c+3)%8] = w;
        end
        k++;
      end
    end
    pixValid = 1'b0; lineStart = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired act 0 exp 1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (4) @(negedge clk);
    checkVal(outValid === 1'b0, "R1 valid low in reset", 32'(outValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkVal(outValid === 1'b0 && regRdData === 16'h0, "R1 outputs after reset",
             {outValid, regRdData}, 0);
    regRead(2'd0, d); checkVal(d === 16'h0000, "R1 control reset", 32'(d), 32'h0);
    regRead(2'd1, d); checkVal(d === 16'h0010, "R1 gain reset", 32'(d), 32'h10);
    regRead(2'd2, d); checkVal(d === 16'h0000, "R1 index reset", 32'(d), 32'h0);

    // Load the table through the auto-incrementing window
    for (int i = 0; i < 1024; i++) lutModel[i] = (i * 613 + 97) % 1024;
    regWrite(2'd2, 16'd0);
    for (int i = 0; i < 1024; i++) regWrite(2'd3, 16'(lutModel[i]));
    regRead(2'd2, d); checkVal(d === 16'd0, "R4 index wrapped after full load", 32'(d), 0);
    regWrite(2'd2, 16'd1020);
    for (int i = 0; i < 8; i++) begin
      regRead(2'd3, d);
      checkVal(d === 16'(lutModel[(1020 + i) % 1024]), "R5 R4 readback across wrap",
               32'(d), 32'(lutModel[(1020 + i) % 1024]));
    end
    regRead(2'd2, d); checkVal(d === 16'd4, "R4 index after reads", 32'(d), 4);
    regWrite(2'd2, 16'd5);
    regWrite(2'd3, 16'h3A5);
    lutModel[5] = 'h3A5;
    regRead(2'd2, d); checkVal(d === 16'd6, "R4 index after one write", 32'(d), 6);
    regRead(2'd1, d); checkVal(d === 16'h0010, "R4 gain untouched by table access", 32'(d), 32'h10);
    regWrite(2'd2, 16'd5);
    regRead(2'd3, d); checkVal(d === 16'h3A5, "R5 single entry rewrite", 32'(d), 32'h3A5);

    runStream(4'b0010, 'h10, 1'b0, 0, "R8 R11 R2 right-justified unity gain");
    runStream(4'b0010, 'h2B, 1'b0, 0, "R2 gain with clip");
    runStream(4'b0010, 'h00, 1'b0, 0, "R2 zero gain");
    runStream(4'b0001, 'h07, 1'b1, 0, "R7 R3 left-justified through table");
    runStream(4'b0010, 'h10, 1'b1, 0, "R3 table map");
    runStream(4'b0000, 'h18, 1'b1, 0, "R6 byte output");
    runStream(4'b0101, 'h10, 1'b0, 0, "R6 undefined code falls back");
    runStream(4'b1000, 'h13, 1'b0, 0, "R9 dense packing");
    runStream(4'b0100, 'h2B, 1'b1, 37, "R10 ramp pattern");
    runStream(4'b0010, 'h10, 1'b0, 0, "R9 R11 leaving packed mode");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule